// File: doc/BRIEF.md
# (1,7) RLL Read Decoder with Two-Bit NRZ Output

This block sits between a read channel's data separator and a disk controller. It takes the separator's already-synchronized serial code stream, one code bit per sync clock period, samples it on the falling edge of that clock, and splits the stream into 3-bit code groups, most significant bit first. Each group is turned back into a 2-bit NRZ symbol. The decoder holds one group in reserve before deciding on it. This look-ahead lets it spot the 000 group that marks a two-group substitution and recover both original pairs.

Decoded pairs are retimed onto a read reference clock that runs without a break at one third of the code clock, and so at half the NRZ bit rate. The controller captures `nrz_o` on each rising edge of `rd_clk_o`. Bit 1 of `nrz_o` is the more significant NRZ bit. A low read gate stops decoding and clears the decoder state. A sticky flag reports code groups that cannot be decoded.

Top module: `rll17_read_decoder`

## Requirements
- R1: `rd_gate` passes through a SYNC_STAGES-flop synchronizer clocked on the falling edge. A code bit is sampled on each falling edge of `sync_clk`. While the synchronized gate is high, bits are grouped in threes and the first bit of each group is the group's bit 2. Framing restarts with the bit sampled on the (SYNC_STAGES+1)th falling edge at which `rd_gate` is high.
- R2: A group that is not followed by 000 decodes as follows: 101 gives NRZ 00, 100 gives 01, 001 gives 10, and 010 gives 11 (written as `nrz_o[1:0]`).
- R3: When 101, 100, 001 or 010 is followed by 000, the two groups together decode to the two pairs 00 00, 00 01, 10 00 or 10 01 respectively, with the first pair output first.
- R4: A group of 111, 110 or 011, or a 000 group that does not complete a substitution, decodes as 00 and sets `err_o`.
- R5: `err_o` stays high while the synchronized gate stays high. While it is low, the decoder state is cleared: `err_o` is 0, `nrz_o` settles to 00, and `sync_data` has no effect.
- R6: `rd_clk_o` runs whatever the state of the gate. Its period is 3 `sync_clk` periods, and it is high for exactly one period in each.
- R7: `nrz_o` changes only while `rd_clk_o` is low, and one `sync_clk` period before `rd_clk_o` rises. Each decoded pair is presented at exactly one rising edge of `rd_clk_o`, and the pairs keep their input order.
- R8: While `rst_n` is low, `nrz_o` is 00, `err_o` is 0 and `rd_clk_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sync_clk | input | 1 | Code-rate clock from the data separator; all state is updated on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rd_gate | input | 1 | Read enable, asynchronous; low clears the decoder |
| sync_data | input | 1 | Serial synchronized code bits, MSB of each group first |
| nrz_o | output | 2 | Decoded NRZ pair, bit 1 most significant |
| rd_clk_o | output | 1 | Free-running read reference clock, one third of the code rate |
| err_o | output | 1 | Sticky flag for an undecodable code group |

## Verification
The bench builds the block with the default SYNC_STAGES of 2, so the point at which framing starts after the gate rises is known to the bit. The bench's own encoder turns every ordered triple of NRZ pairs into code. Because of this, each basic code word and each of the four substitutions is exercised at the start, the middle and the end of a burst, next to every possible neighbour. One long pseudo-random burst, hand-built illegal streams (including a 000 group that does not complete a substitution), aborted partial groups and gate-low noise cover the error, clearing and retiming rules. The spacing of the read clock is monitored on every cycle.

// File: rtl/rll_dec_pkg.sv
package rll_dec_pkg;

  localparam int GRP_W  = 3;
  localparam int PAIR_W = 2;

  typedef logic [GRP_W-1:0]  grp_t;
  typedef logic [PAIR_W-1:0] pair_t;

  typedef struct packed {
    pair_t first;
    pair_t second;
    logic  sub;
    logic  bad;
  } dec_res_t;

  // Decode one group, using the group that follows it as look-ahead.
  function automatic dec_res_t decode_grp(grp_t cur, grp_t nxt);
    dec_res_t r;
    pair_t    basic;
    pair_t    sfirst;
    pair_t    ssecond;
    logic     legal;
    legal   = 1'b1;
    basic   = '0;
    sfirst  = '0;
    ssecond = '0;
    case (cur)
      3'b101:  begin basic = 2'b00; sfirst = 2'b00; ssecond = 2'b00; end
      3'b100:  begin basic = 2'b01; sfirst = 2'b00; ssecond = 2'b01; end
      3'b001:  begin basic = 2'b10; sfirst = 2'b10; ssecond = 2'b00; end
      3'b010:  begin basic = 2'b11; sfirst = 2'b10; ssecond = 2'b01; end
      default: legal = 1'b0;
    endcase
    r.bad    = !legal;
    r.sub    = legal && (nxt == '0);
    r.first  = !legal ? '0 : (r.sub ? sfirst : basic);
    r.second = ssecond;
    return r;
  endfunction

endpackage

// File: rtl/rll_dec_sync.sv
module rll_dec_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_n;

  always_comb begin
    chain_n = {chain_q[STAGES-2:0], d_i};
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_n;
    end
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/rll_dec_framer.sv
module rll_dec_framer
  import rll_dec_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic gate_i,
  input  logic din_i,
  output grp_t grp_o,
  output logic vld_o
);

  localparam int CNT_W = $clog2(GRP_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(GRP_W - 1);

  logic [GRP_W-2:0] sh_q, sh_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  grp_t             grp_q, grp_n;
  logic             vld_q, vld_n;

  always_comb begin
    sh_n  = sh_q;
    cnt_n = cnt_q;
    grp_n = grp_q;
    vld_n = 1'b0;
    if (!gate_i) begin
      cnt_n = '0;
    end else if (cnt_q == LAST) begin
      grp_n = {sh_q, din_i};
      vld_n = 1'b1;
      cnt_n = '0;
    end else begin
      sh_n  = {sh_q[GRP_W-3:0], din_i};
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      grp_q <= '0;
      vld_q <= 1'b0;
    end else begin
      sh_q  <= sh_n;
      cnt_q <= cnt_n;
      grp_q <= grp_n;
      vld_q <= vld_n;
    end
  end

  assign grp_o = grp_q;
  assign vld_o = vld_q;

  AST_GROUP_SPACING: assert property (@(negedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q); // R1

  AST_GATE_HALTS_FRAMING: assert property (@(negedge clk) disable iff (!rst_n)
    !gate_i |=> !vld_q); // R5

endmodule

// File: rtl/rll_dec_core.sv
module rll_dec_core
  import rll_dec_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  gate_i,
  input  logic  vld_i,
  input  grp_t  grp_i,
  output pair_t dec_o,
  output logic  err_o
);

  grp_t     prev_q, prev_n;
  logic     pvld_q, pvld_n;
  logic     sub_q, sub_n;
  pair_t    hold_q, hold_n;
  pair_t    dec_q, dec_n;
  logic     err_q, err_n;
  dec_res_t res;

  always_comb begin
    res    = decode_grp(prev_q, grp_i);
    prev_n = prev_q;
    pvld_n = pvld_q;
    sub_n  = sub_q;
    hold_n = hold_q;
    dec_n  = dec_q;
    err_n  = err_q;
    if (!gate_i) begin
      pvld_n = 1'b0;
      sub_n  = 1'b0;
      dec_n  = '0;
      err_n  = 1'b0;
    end else if (vld_i) begin
      prev_n = grp_i;
      pvld_n = 1'b1;
      if (pvld_q) begin
        if (sub_q) begin
          dec_n = hold_q;
          sub_n = 1'b0;
        end else begin
          dec_n  = res.first;
          sub_n  = res.sub;
          hold_n = res.second;
          if (res.bad) begin
            err_n = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pvld_q <= 1'b0;
      sub_q  <= 1'b0;
      hold_q <= '0;
      dec_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      prev_q <= prev_n;
      pvld_q <= pvld_n;
      sub_q  <= sub_n;
      hold_q <= hold_n;
      dec_q  <= dec_n;
      err_q  <= err_n;
    end
  end

  assign dec_o = dec_q;
  assign err_o = err_q;

  AST_ERR_STICKY: assert property (@(negedge clk) disable iff (!rst_n)
    (gate_i && err_q) |=> err_q); // R5

  AST_GATE_FLUSH: assert property (@(negedge clk) disable iff (!rst_n)
    !gate_i |=> (!err_q && dec_q == '0 && !sub_q)); // R5

  AST_SUB_NEEDS_ZERO: assert property (@(negedge clk) disable iff (!rst_n)
    (sub_q && gate_i && vld_i) |=> !sub_q); // R3

endmodule

// File: rtl/rll_dec_clkgen.sv
module rll_dec_clkgen
  import rll_dec_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  pair_t dec_i,
  output pair_t nrz_o,
  output logic  rd_clk_o
);

  localparam int DIV   = GRP_W;
  localparam int DIV_W = $clog2(DIV);
  localparam logic [DIV_W-1:0] TOP     = DIV_W'(DIV - 1);
  localparam logic [DIV_W-1:0] RISE_PH = DIV_W'(1);

  logic [DIV_W-1:0] div_q, div_n;
  logic             rclk_q, rclk_n;
  pair_t            nrz_q, nrz_n;

  always_comb begin
    div_n  = (div_q == TOP) ? '0 : div_q + 1'b1;
    rclk_n = (div_n == RISE_PH);
    nrz_n  = (div_n == '0) ? dec_i : nrz_q;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      rclk_q <= 1'b0;
      nrz_q  <= '0;
    end else begin
      div_q  <= div_n;
      rclk_q <= rclk_n;
      nrz_q  <= nrz_n;
    end
  end

  assign nrz_o    = nrz_q;
  assign rd_clk_o = rclk_q;

  AST_RDCLK_PULSE: assert property (@(negedge clk) disable iff (!rst_n)
    rclk_q |=> !rclk_q); // R6

  AST_RDCLK_RETURN: assert property (@(negedge clk) disable iff (!rst_n)
    $fell(rclk_q) |=> !rclk_q ##1 rclk_q); // R6

  AST_NRZ_SETUP: assert property (@(negedge clk) disable iff (!rst_n)
    !$stable(nrz_q) |-> (!rclk_q ##1 rclk_q)); // R7

endmodule

// File: rtl/rll17_read_decoder.sv
module rll17_read_decoder
  import rll_dec_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        sync_clk,
  input  logic        rst_n,
  input  logic        rd_gate,
  input  logic        sync_data,
  output logic [1:0]  nrz_o,
  output logic        rd_clk_o,
  output logic        err_o
);

  logic  rst_n_s;
  logic  gate_s;
  grp_t  grp;
  logic  grp_vld;
  pair_t dec;

  rll_dec_sync #(.STAGES(SYNC_STAGES)) rst_sync_i (
    .clk   (sync_clk),
    .rst_n (rst_n),
    .d_i   (1'b1),
    .q_o   (rst_n_s)
  );

  rll_dec_sync #(.STAGES(SYNC_STAGES)) gate_sync_i (
    .clk   (sync_clk),
    .rst_n (rst_n_s),
    .d_i   (rd_gate),
    .q_o   (gate_s)
  );

  rll_dec_framer framer_i (
    .clk    (sync_clk),
    .rst_n  (rst_n_s),
    .gate_i (gate_s),
    .din_i  (sync_data),
    .grp_o  (grp),
    .vld_o  (grp_vld)
  );

  rll_dec_core core_i (
    .clk    (sync_clk),
    .rst_n  (rst_n_s),
    .gate_i (gate_s),
    .vld_i  (grp_vld),
    .grp_i  (grp),
    .dec_o  (dec),
    .err_o  (err_o)
  );

  rll_dec_clkgen clkgen_i (
    .clk      (sync_clk),
    .rst_n    (rst_n_s),
    .dec_i    (dec),
    .nrz_o    (nrz_o),
    .rd_clk_o (rd_clk_o)
  );

  AST_RESET_QUIET: assert property (@(negedge sync_clk)
    !rst_n_s |-> (nrz_o == '0 && !err_o && !rd_clk_o)); // R8

endmodule

// File: tb/rll17_read_decoder_tb_top.sv
module rll17_read_decoder_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rd_gate;
  logic       sync_data;
  logic [1:0] nrz_o;
  logic       rd_clk_o;
  logic       err_o;

  always #2 clk = ~clk;

  rll17_read_decoder #(.SYNC_STAGES(2)) dut_i (
    .sync_clk  (clk),
    .rst_n     (rst_n),
    .rd_gate   (rd_gate),
    .sync_data (sync_data),
    .nrz_o     (nrz_o),
    .rd_clk_o  (rd_clk_o),
    .err_o     (err_o)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int seq[0:127];
  int subf[0:127];
  int nseq;
  int ndata;
  int grp_a[0:255];
  int ng;
  int expv[0:127];
  int exptag[0:127];
  int nexp;
  int cap_buf[0:511];
  int cap_n = 0;
  bit cap_en = 1'b0;

  bit mon_on = 1'b0;
  bit seen_rise = 1'b0;
  bit prev_rc = 1'b0;
  int since = 0;
  int rc_bad = 0;
  int rises = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Read-clock monitor and capture at each rising edge.
  always @(posedge clk) begin
    if (mon_on) begin
      since = since + 1;
      if (rd_clk_o && prev_rc) rc_bad++;
      if (rd_clk_o && !prev_rc) begin
        if (seen_rise && since != 3) rc_bad++;
        since = 0;
        seen_rise = 1'b1;
        rises++;
        if (cap_en && cap_n < 512) begin
          cap_buf[cap_n] = int'(nrz_o);
          cap_n++;
        end
      end
    end
    prev_rc = rd_clk_o;
  end

  function automatic int basic_code(input int p);
    case (p)
      0: return 3'b101;
      1: return 3'b100;
      2: return 3'b001;
      default: return 3'b010;
    endcase
  endfunction

  // Build code groups from seq[0..nseq-1] (leading and trailing 11 included).
  task automatic encode();
    int i;
    ng = 0;
    i = 0;
    while (i < nseq) begin
      int a;
      int b;
      a = seq[i];
      b = (i + 1 < nseq) ? seq[i+1] : 3;
      if ((a == 0 || a == 2) && (b == 0 || b == 1)) begin
        grp_a[ng] = (a == 0) ? ((b == 0) ? 3'b101 : 3'b100)
                             : ((b == 0) ? 3'b001 : 3'b010);
        grp_a[ng+1] = 0;
        ng += 2;
        subf[i] = 1;
        subf[i+1] = 1;
        i += 2;
      end else begin
        grp_a[ng] = basic_code(a);
        subf[i] = 0;
        ng++;
        i++;
      end
    end
    nexp = ndata + 1;
    for (int k = 0; k < nexp; k++) begin
      expv[k] = seq[k];
      exptag[k] = subf[k] ? 3 : 2;
    end
  endtask

  task automatic set_data(input int n);
    ndata = n;
    nseq = n + 5;
    seq[0] = 3;
    for (int k = 0; k < 4; k++) seq[n+1+k] = 3;
  endtask

  // Send grp_a through the decoder and compare captured pairs.
  task automatic run_burst(input bit exp_err, input string label);
    int k;
    int e;
    cap_n = 0;
    cap_en = 1'b1;
    rd_gate = 1'b1;
    repeat (2) @(posedge clk);
    for (int g = 0; g < ng; g++) begin
      for (int b = 2; b >= 0; b--) begin
        sync_data = grp_a[g][b];
        @(posedge clk);
      end
    end
    sync_data = 1'b0;
    e = int'(err_o);
    cap_en = 1'b0;
    rd_gate = 1'b0;
    repeat (8) @(posedge clk);
    chk(e == int'(exp_err), exp_err ? "R4" : "R5",
        {label, " err flag at end of burst"}, e, int'(exp_err));
    k = -1;
    for (int i = 0; i < cap_n; i++) begin
      if (k < 0 && cap_buf[i] == 3) k = i;
    end
    chk(k >= 0 && k + nexp <= cap_n, "R1", {label, " framing alignment"},
        k, 0);
    if (k >= 0 && k + nexp <= cap_n) begin
      for (int i = 0; i < nexp; i++) begin
        if (exptag[i] == 3)
          chk(cap_buf[k+i] == expv[i], "R3", {label, " pair"}, cap_buf[k+i], expv[i]);
        else if (exptag[i] == 4)
          chk(cap_buf[k+i] == expv[i], "R4", {label, " pair"}, cap_buf[k+i], expv[i]);
        else
          chk(cap_buf[k+i] == expv[i], "R2", {label, " pair"}, cap_buf[k+i], expv[i]);
      end
      for (int i = 0; i < k; i++)
        chk(cap_buf[i] == 0, "R7", {label, " idle pair before data"}, cap_buf[i], 0);
    end
    chk(err_o == 1'b0 && nrz_o == 2'b00, "R5", {label, " cleared after gate low"},
        int'({err_o, nrz_o}), 0);
  endtask

  task automatic raw_burst(input int g0, input int g1, input int g2, input int g3,
                           input int e1, input int e2, input int e3, input int e4,
                           input string label);
    ng = 8;
    grp_a[0] = 3'b010; grp_a[1] = g0; grp_a[2] = g1; grp_a[3] = g2; grp_a[4] = g3;
    grp_a[5] = 3'b010; grp_a[6] = 3'b010; grp_a[7] = 3'b010;
    nexp = 5;
    expv[0] = 3; expv[1] = e1; expv[2] = e2; expv[3] = e3; expv[4] = e4;
    exptag[0] = 2; exptag[1] = 4; exptag[2] = 4; exptag[3] = 4; exptag[4] = 4;
    run_burst(1'b1, label);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int lfsr;
    int bad;
    rst_n = 1'b0;
    rd_gate = 1'b0;
    sync_data = 1'b0;
    repeat (4) @(posedge clk);
    // R8: reset values
    chk(nrz_o == 2'b00 && err_o == 1'b0 && rd_clk_o == 1'b0, "R8",
        "outputs during reset", int'({rd_clk_o, err_o, nrz_o}), 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    mon_on = 1'b1;
    repeat (12) @(posedge clk);

    // R5: gate low, noise on sync_data has no effect
    bad = 0;
    for (int i = 0; i < 24; i++) begin
      sync_data = ((i * 5) % 3 != 0);
      @(posedge clk);
      if (nrz_o != 2'b00 || err_o) bad++;
    end
    sync_data = 1'b0;
    chk(bad == 0, "R5", "gate-low noise ignored", bad, 0);

    // R1: aborted partial group, then framing must restart cleanly
    rd_gate = 1'b1;
    repeat (2) @(posedge clk);
    sync_data = 1'b1; @(posedge clk);
    sync_data = 1'b1; @(posedge clk);
    sync_data = 1'b0;
    rd_gate = 1'b0;
    repeat (8) @(posedge clk);
    set_data(3);
    seq[1] = 2; seq[2] = 0; seq[3] = 1;
    encode();
    run_burst(1'b0, "restart after abort");

    // R2/R3: every ordered triple of pairs
    for (int t = 0; t < 64; t++) begin
      set_data(3);
      seq[1] = (t >> 4) & 3;
      seq[2] = (t >> 2) & 3;
      seq[3] = t & 3;
      encode();
      run_burst(1'b0, $sformatf("triple %0d", t));
    end

    // R2/R3/R7: long pseudo-random burst
    lfsr = 16'hACE1;
    set_data(60);
    for (int i = 1; i <= 60; i++) begin
      lfsr = ((lfsr >> 1) | (((lfsr ^ (lfsr >> 2) ^ (lfsr >> 3) ^ (lfsr >> 5)) & 1) << 15)) & 16'hFFFF;
      seq[i] = lfsr & 3;
    end
    encode();
    run_burst(1'b0, "long burst");

    // R4: illegal groups decode as 00 and raise the sticky flag
    raw_burst(3'b111, 3'b010, 3'b110, 3'b010, 0, 3, 0, 3, "illegal 111/110");
    raw_burst(3'b011, 3'b010, 3'b010, 3'b010, 0, 3, 3, 3, "illegal 011");
    raw_burst(3'b101, 3'b000, 3'b000, 3'b010, 0, 0, 0, 3, "unpaired 000");
    expv[1] = 0;

    // R6: read clock spacing over the whole run
    chk(rc_bad == 0, "R6", "read clock period/width violations", rc_bad, 0);
    chk(rises > 100, "R6", "read clock kept running", rises, 101);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule